// File: doc/BRIEF.md
# Floating-Point Register Stack Tag Word Unit

This unit holds the tag word that describes what each of the eight physical registers of a floating-point register stack contains. Each register has a 2-bit tag. When a register is written, the unit looks at the incoming 80-bit extended-format value and stores the matching tag for that register. Three other commands change tags without a write. A free command marks one register empty. A load command replaces the whole word. An initialize command, which is also used for a state save, marks every register empty.

The register storage and the stack-top pointer are outside this unit. The caller resolves the physical register index before it issues a write or a free. The tag word is always visible on the output. Every change appears one clock after the command that causes it.

Top module: `fp_tag_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, the tag word reads 16'hFFFF, which marks every register empty (tag code 2'b11).
- R2: An initialize command sets the tag word to 16'hFFFF on the next clock. It takes priority over load, write and free in the same cycle.
- R3: Writing a zero to register i sets bits 2i+1:2i to 2'b01. A zero has exponent (bits 78:64) equal to 0 and significand (bits 63:0) equal to 0.
- R4: Writing a value with an exponent that is neither 0 nor all ones and with integer bit 63 set sets register i's tag to 2'b00 (valid).
- R5: Writing a value with exponent 0 and a nonzero significand (a denormal) sets the tag to 2'b10 (special).
- R6: Writing a value with an all-ones exponent (infinity or NaN) sets the tag to 2'b10.
- R7: Writing a value with a nonzero exponent that is not all ones and a clear integer bit 63 (an unsupported encoding) sets the tag to 2'b10.
- R8: A free command on index i sets only register i's tag to 2'b11. All other tags keep their values.
- R9: A load command copies the 16-bit load word into the tag word on the next clock. It takes priority over write and free in the same cycle.
- R10: If a free and a write target the same index in one cycle, the free wins and the tag becomes 2'b11. If they target different indices, both take effect.
- R11: A write changes only the addressed register's tag. With no command present, the tag word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Initialize/save command: marks all registers empty |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | 3 | Physical index of the written register |
| wr_data_i | input | 80 | Extended-format value being written (sign 79, exponent 78:64, significand 63:0) |
| free_en_i | input | 1 | Free command: marks one register empty |
| free_idx_i | input | 3 | Physical index of the freed register |
| load_en_i | input | 1 | Full tag word load |
| load_word_i | input | 16 | Tag word to load |
| tag_word_o | output | 16 | Current tag word, register i at bits 2i+1:2i |

## Verification
The assertions assume that the command inputs are known, 0 or 1, on every clock edge after reset. They also assume that an index only matters while its strobe is high. None of them restricts how commands combine, so any mix of initialize, load, write and free is legal. The stimulus holds every input steady from one falling edge to the next. It issues the commands in every combination, including free and write to the same index. Its data values come from each encoding class and also from unconstrained random bits.

// File: rtl/fptag_pkg.sv
package fptag_pkg;
  typedef enum logic [1:0] {
    TAG_VALID   = 2'b00,
    TAG_ZERO    = 2'b01,
    TAG_SPECIAL = 2'b10,
    TAG_EMPTY   = 2'b11
  } tag_e;
  localparam int unsigned TAG_W = 2;
endpackage

// File: rtl/fptag_classify.sv
module fptag_classify
  import fptag_pkg::*;
#(
  parameter int unsigned EXP_W = 15,
  parameter int unsigned SIG_W = 64
) (
  input  logic [EXP_W+SIG_W:0] value_i,
  output tag_e                 tag_o
);
  logic [EXP_W-1:0] exp_f;
  logic [SIG_W-1:0] sig_f;
  logic             exp_zero, exp_max, int_bit, sig_zero;

  assign exp_f    = value_i[EXP_W+SIG_W-1 -: EXP_W];
  assign sig_f    = value_i[SIG_W-1:0];
  assign exp_zero = (exp_f == '0);
  assign exp_max  = &exp_f;
  assign sig_zero = (sig_f == '0);
  assign int_bit  = sig_f[SIG_W-1];

  always_comb begin
    if (exp_zero)     tag_o = sig_zero ? TAG_ZERO : TAG_SPECIAL;
    else if (exp_max) tag_o = TAG_SPECIAL;
    else if (!int_bit) tag_o = TAG_SPECIAL;
    else              tag_o = TAG_VALID;
  end
endmodule

// File: rtl/fptag_store.sv
module fptag_store
  import fptag_pkg::*;
#(
  parameter int unsigned NREGS = 8,
  localparam int unsigned IDX_W = $clog2(NREGS),
  localparam int unsigned WORD_W = NREGS * TAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              load_en_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  tag_e              wr_tag_i,
  input  logic              free_en_i,
  input  logic [IDX_W-1:0]  free_idx_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar g = 0; g < NREGS; g++) begin : g_cell
    logic       hit_wr, hit_free, cell_en;
    logic [1:0] cell_d, cell_q;

    assign hit_wr   = wr_en_i   && (wr_idx_i   == IDX_W'(g));
    assign hit_free = free_en_i && (free_idx_i == IDX_W'(g));
    assign cell_en  = init_i | load_en_i | hit_wr | hit_free;

    always_comb begin
      if (init_i)         cell_d = TAG_EMPTY;
      else if (load_en_i) cell_d = load_word_i[g*TAG_W +: TAG_W];
      else if (hit_free)  cell_d = TAG_EMPTY;
      else if (hit_wr)    cell_d = wr_tag_i;
      else                cell_d = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= TAG_EMPTY;
      else if (cell_en) cell_q <= cell_d;
    end

    assign word_o[g*TAG_W +: TAG_W] = cell_q;
  end
endmodule

// File: rtl/fp_tag_unit.sv
module fp_tag_unit
  import fptag_pkg::*;
#(
  parameter int unsigned NREGS = 8,
  parameter int unsigned EXP_W = 15,
  parameter int unsigned SIG_W = 64,
  localparam int unsigned IDX_W  = $clog2(NREGS),
  localparam int unsigned WORD_W = NREGS * TAG_W,
  localparam int unsigned DATA_W = 1 + EXP_W + SIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              free_en_i,
  input  logic [IDX_W-1:0]  free_idx_i,
  input  logic              load_en_i,
  input  logic [WORD_W-1:0] load_word_i,
  output logic [WORD_W-1:0] tag_word_o
);
  tag_e wr_tag;

  fptag_classify #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_classify (
    .value_i (wr_data_i),
    .tag_o   (wr_tag)
  );

  fptag_store #(.NREGS(NREGS)) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (init_i),
    .load_en_i   (load_en_i),
    .load_word_i (load_word_i),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_tag_i    (wr_tag),
    .free_en_i   (free_en_i),
    .free_idx_i  (free_idx_i),
    .word_o      (tag_word_o)
  );
endmodule

// File: rtl/fptag_checker.sv
module fptag_checker #(
  parameter int unsigned NREGS = 8,
  parameter int unsigned EXP_W = 15,
  parameter int unsigned SIG_W = 64,
  localparam int unsigned IDX_W  = $clog2(NREGS),
  localparam int unsigned WORD_W = NREGS * 2,
  localparam int unsigned DATA_W = 1 + EXP_W + SIG_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_i,
  input logic              wr_en_i,
  input logic [IDX_W-1:0]  wr_idx_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              free_en_i,
  input logic [IDX_W-1:0]  free_idx_i,
  input logic              load_en_i,
  input logic [WORD_W-1:0] load_word_i,
  input logic [WORD_W-1:0] tag_word_o
);
  function automatic logic [1:0] fld(input logic [WORD_W-1:0] w, input logic [IDX_W-1:0] i);
    return w[i*2 +: 2];
  endfunction

  logic plain_wr, wr_zero, wr_denorm, wr_infnan;
  assign plain_wr  = !init_i && !load_en_i && wr_en_i && !(free_en_i && free_idx_i == wr_idx_i);
  assign wr_zero   = wr_data_i[DATA_W-2:0] == '0;
  assign wr_denorm = wr_data_i[DATA_W-2 -: EXP_W] == '0 && wr_data_i[SIG_W-1:0] != '0;
  assign wr_infnan = &wr_data_i[DATA_W-2 -: EXP_W];

  AST_INIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> tag_word_o == '1); // R2
  AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && load_en_i) |=> tag_word_o == $past(load_word_i)); // R9
  AST_FREE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !load_en_i && free_en_i) |=> fld(tag_word_o, $past(free_idx_i)) == 2'b11); // R8
  AST_WR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_wr && wr_zero) |=> fld(tag_word_o, $past(wr_idx_i)) == 2'b01); // R3
  AST_WR_DENORM: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_wr && wr_denorm) |=> fld(tag_word_o, $past(wr_idx_i)) == 2'b10); // R5
  AST_WR_INFNAN: assert property (@(posedge clk) disable iff (!rst_n)
    (plain_wr && wr_infnan) |=> fld(tag_word_o, $past(wr_idx_i)) == 2'b10); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !load_en_i && !wr_en_i && !free_en_i) |=> $stable(tag_word_o)); // R11
endmodule

bind fp_tag_unit fptag_checker #(.NREGS(NREGS), .EXP_W(EXP_W), .SIG_W(SIG_W)) u_fptag_checker (.*);

// File: tb/test_fp_tag_unit.sv
module test_fp_tag_unit;
  logic        clk;
  logic        rst_n;
  logic        init_i, wr_en_i, free_en_i, load_en_i;
  logic [2:0]  wr_idx_i, free_idx_i;
  logic [79:0] wr_data_i;
  logic [15:0] load_word_i;
  logic [15:0] tag_word_o;

  int vectors = 0;
  int miscompares = 0;
  int model [8];
  bit done = 0;

  fp_tag_unit i_fp_tag_unit (.*);

  initial clk = 0;
  always #2 clk = ~clk;

  function automatic int classify(input logic [79:0] v);
    logic [14:0] e;
    logic [63:0] s;
    e = v[78:64];
    s = v[63:0];
    if (e == 15'h7FFF) return 2;
    if (e == 0) return (s == 0) ? 1 : 2;
    if (s[63] == 1'b0) return 2;
    return 0;
  endfunction

  function automatic logic [15:0] model_word();
    logic [15:0] w;
    for (int k = 0; k < 8; k++) w[k*2 +: 2] = 2'(model[k]);
    return w;
  endfunction

  task automatic compare(input string req);
    vectors++;
    if (tag_word_o !== model_word()) begin
      miscompares++;
      $display("FAIL %s: tag word actual %h expected %h", req, tag_word_o, model_word());
    end
  endtask

  task automatic apply(input bit ini, input bit wr, input int widx, input logic [79:0] d,
                       input bit fr, input int fidx, input bit ld, input logic [15:0] lw,
                       input string req);
    init_i = ini; wr_en_i = wr; wr_idx_i = 3'(widx); wr_data_i = d;
    free_en_i = fr; free_idx_i = 3'(fidx); load_en_i = ld; load_word_i = lw;
    if (ini) begin
      for (int k = 0; k < 8; k++) model[k] = 3;
    end else if (ld) begin
      for (int k = 0; k < 8; k++) model[k] = int'(lw[k*2 +: 2]);
    end else begin
      if (wr) model[widx] = classify(d);
      if (fr) model[fidx] = 3;
    end
    @(negedge clk);
    compare(req);
  endtask

  function automatic logic [79:0] mk(input int kind);
    logic [79:0] v;
    v = {$urandom, $urandom, $urandom};
    case (kind)
      0: v[78:0] = '0;                                      // zero
      1: begin v[78:64] = '0; v[63:0] = 64'h1 | {$urandom, $urandom}; end // denormal
      2: begin v[78:64] = 15'h7FFF; end                     // inf / nan
      3: begin v[78:64] = 15'h3FFF; v[63] = 1'b1; end       // normal
      4: begin v[78:64] = 15'h0001; v[63] = 1'b0; end       // unsupported
      default: ;
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!done && vectors == 0 && $time > 400000) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected progress");
    end
  end

  initial begin
    #300000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    init_i = 0; wr_en_i = 0; free_en_i = 0; load_en_i = 0;
    wr_idx_i = 0; free_idx_i = 0; wr_data_i = '0; load_word_i = '0;
    for (int k = 0; k < 8; k++) model[k] = 3;
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after release");

    apply(0,1,0,mk(0),0,0,0,'0,"R3 zero");
    apply(0,1,1,mk(3),0,0,0,'0,"R4 valid");
    apply(0,1,2,mk(1),0,0,0,'0,"R5 denormal");
    apply(0,1,3,mk(2),0,0,0,'0,"R6 inf/nan");
    apply(0,1,4,mk(4),0,0,0,'0,"R7 unsupported");
    apply(0,1,7,{1'b1,15'h7FFE,1'b1,63'h0},0,0,0,'0,"R4 max normal");
    apply(0,1,6,{1'b0,15'h0001,1'b0,63'h5},0,0,0,'0,"R7 min exp unnormal");
    apply(0,0,0,'0,0,0,0,'0,"R11 idle hold");
    apply(0,0,0,'0,1,1,0,'0,"R8 free one");
    apply(0,1,5,mk(0),1,5,0,'0,"R10 free beats write");
    apply(0,1,5,mk(3),1,2,0,'0,"R10 distinct both apply");
    apply(0,1,0,mk(2),1,3,1,16'h1B4E,"R9 load beats write/free");
    apply(1,1,0,mk(0),1,3,1,16'h0000,"R2 init beats all");
    apply(0,1,2,mk(3),0,0,0,'0,"R11 single register");

    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      apply(r < 3, $urandom_range(0,1) == 1, int'($urandom_range(0,7)), mk(int'($urandom_range(0,5))),
            $urandom_range(0,3) == 0, int'($urandom_range(0,7)), r >= 3 && r < 7,
            16'($urandom), "R2-mix R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule